// File: doc/BRIEF.md
# Registered AXI-Stream Loopback Stage

This block sits between a memory-to-stream channel and a stream-to-memory channel. It takes one word at a time from its AXI-Stream input, latches the word together with its byte qualifiers and its end-of-packet flag in a holding register, and then offers that word on its AXI-Stream output. The holding register is the place where later data processing would go. For now it passes each word through unchanged.

The block works as a two-state machine. In the receive state it asserts the input ready. In the send state it asserts the output valid and holds the input ready low. Each word therefore makes exactly one handshake on each side. The downstream byte count cannot drift, because no word is ever offered twice. Both interfaces share one clock and one synchronous active-low reset. The best-case rate is one word every two cycles.

Top module: `axis_loopback_stage`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to receive: after that edge `s_axis_tready` is 1 and `m_axis_tvalid` is 0.
- R2: A word is accepted only at an edge where `s_axis_tvalid` and `s_axis_tready` are both 1. From the next cycle `m_axis_tvalid` is 1 and `m_axis_tdata` equals the accepted data.
- R3: `s_axis_tready` and `m_axis_tvalid` are never 1 in the same cycle, so at most one word is held.
- R4: While `m_axis_tvalid` is 1 and `m_axis_tready` is 0, `m_axis_tdata`, `m_axis_tkeep` and `m_axis_tlast` keep their values into the next cycle.
- R5: After an edge where `m_axis_tvalid` and `m_axis_tready` are both 1, `m_axis_tvalid` is 0 and `s_axis_tready` is 1 in the next cycle. The word is never presented for a second handshake.
- R6: `m_axis_tlast` carries the end-of-packet flag that arrived with the same word.
- R7: `m_axis_tkeep` is `DATA_W/8` bits wide, one bit per byte of `m_axis_tdata` (bit i covers bits 8i+7..8i). It equals the `s_axis_tkeep` accepted with the same word.
- R8: Words leave in the order they were accepted, each exactly once, under any pattern of input gaps and output back-pressure.
- R9: Changes on the input data, keep, last and valid lines while the block is in the send state have no effect on the word being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both interfaces |
| rst_n | input | 1 | Synchronous reset, active low |
| s_axis_tdata | input | DATA_W | Incoming word |
| s_axis_tkeep | input | DATA_W/8 | Byte qualifiers of the incoming word |
| s_axis_tlast | input | 1 | Incoming word ends a packet |
| s_axis_tvalid | input | 1 | Incoming word is valid |
| s_axis_tready | output | 1 | Block can take a word |
| m_axis_tdata | output | DATA_W | Outgoing word |
| m_axis_tkeep | output | DATA_W/8 | Byte qualifiers of the outgoing word |
| m_axis_tlast | output | 1 | Outgoing word ends a packet |
| m_axis_tvalid | output | 1 | Outgoing word is valid |
| m_axis_tready | input | 1 | Downstream can take a word |

## Verification
An input handshake at rising edge k makes the word visible on the output from just after edge k. With output ready high, the output handshake lands at edge k+1, and input ready returns just after that edge. The bench drives inputs on falling edges and samples 1 to 2 ns after them. Every result is therefore read in the half cycle that follows the edge producing it. The scoreboard records an expected word at the edge of each input handshake. It compares at the falling edge that comes before each output handshake edge, so a duplicate or missing word shows up as a queue mismatch.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic {
    LBK_RECV = 1'b0,
    LBK_SEND = 1'b1
  } lbk_state_e;

  function automatic logic lbk_fire(input logic valid, input logic ready);
    return valid & ready;
  endfunction

  function automatic lbk_state_e lbk_next(input lbk_state_e cur,
                                          input logic in_fire,
                                          input logic out_fire);
    lbk_state_e nxt;
    nxt = cur;
    case (cur)
      LBK_RECV: if (in_fire)  nxt = LBK_SEND;
      LBK_SEND: if (out_fire) nxt = LBK_RECV;
      default:                nxt = LBK_RECV;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/lbk_ctrl.sv
module lbk_ctrl
  import lbk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_fire,
  input  logic out_fire,
  output logic take_ready,
  output logic give_valid
);

  lbk_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LBK_RECV;
    else        state_q <= lbk_next(state_q, in_fire, out_fire);
  end

  assign take_ready = (state_q == LBK_RECV);
  assign give_valid = (state_q == LBK_SEND);

endmodule

// File: rtl/lbk_hold.sv
module lbk_hold #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic [KEEP_W-1:0] d_keep,
  input  logic              d_last,
  output logic [DATA_W-1:0] q_data,
  output logic [KEEP_W-1:0] q_keep,
  output logic              q_last
);

  localparam int SLOT_W = DATA_W + KEEP_W + 1;

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    slot_q <= '0;
    else if (load) slot_q <= {d_last, d_keep, d_data};
  end

  assign q_data = slot_q[DATA_W-1:0];
  assign q_keep = slot_q[DATA_W +: KEEP_W];
  assign q_last = slot_q[SLOT_W-1];

endmodule

// File: rtl/axis_loopback_stage.sv
module axis_loopback_stage
  import lbk_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int KEEP_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_axis_tdata,
  input  logic [KEEP_W-1:0] s_axis_tkeep,
  input  logic              s_axis_tlast,
  input  logic              s_axis_tvalid,
  output logic              s_axis_tready,
  output logic [DATA_W-1:0] m_axis_tdata,
  output logic [KEEP_W-1:0] m_axis_tkeep,
  output logic              m_axis_tlast,
  output logic              m_axis_tvalid,
  input  logic              m_axis_tready
);

  logic in_fire;
  logic out_fire;
  logic take_ready;
  logic give_valid;

  assign in_fire  = lbk_fire(s_axis_tvalid, take_ready);
  assign out_fire = lbk_fire(give_valid, m_axis_tready);

  lbk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fire    (in_fire),
    .out_fire   (out_fire),
    .take_ready (take_ready),
    .give_valid (give_valid)
  );

  lbk_hold #(
    .DATA_W (DATA_W),
    .KEEP_W (KEEP_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_fire),
    .d_data (s_axis_tdata),
    .d_keep (s_axis_tkeep),
    .d_last (s_axis_tlast),
    .q_data (m_axis_tdata),
    .q_keep (m_axis_tkeep),
    .q_last (m_axis_tlast)
  );

  assign s_axis_tready = take_ready;
  assign m_axis_tvalid = give_valid;

endmodule

// File: rtl/lbk_checker.sv
module lbk_checker #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] s_tdata,
  input logic [KEEP_W-1:0] s_tkeep,
  input logic              s_tlast,
  input logic              s_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic [KEEP_W-1:0] m_tkeep,
  input logic              m_tlast,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              in_fire,
  input logic              out_fire
);

  // R2, R6, R7, R9: accepted word appears on the output next cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> m_tvalid && (m_tdata == $past(s_tdata)) &&
                (m_tkeep == $past(s_tkeep)) && (m_tlast == $past(s_tlast)));

  // R3: one word held at most
  a_r3_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !s_tready);

  // R4: output held under back-pressure
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> m_tvalid && $stable(m_tdata) &&
                               $stable(m_tkeep) && $stable(m_tlast));

  // R5: no second handshake for the same word
  a_r5_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |=> !m_tvalid && s_tready);

endmodule

bind axis_loopback_stage lbk_checker #(
  .DATA_W (DATA_W),
  .KEEP_W (KEEP_W)
) u_lbk_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_tdata  (s_axis_tdata),
  .s_tkeep  (s_axis_tkeep),
  .s_tlast  (s_axis_tlast),
  .s_tready (s_axis_tready),
  .m_tdata  (m_axis_tdata),
  .m_tkeep  (m_axis_tkeep),
  .m_tlast  (m_axis_tlast),
  .m_tvalid (m_axis_tvalid),
  .m_tready (m_axis_tready),
  .in_fire  (in_fire),
  .out_fire (out_fire)
);

// File: tb/test_axis_loopback_stage.sv
module test_axis_loopback_stage;

  localparam int DW = 32;
  localparam int KW = DW / 8;
  localparam int EW = DW + KW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] s_tdata = '0;
  logic [KW-1:0] s_tkeep = '0;
  logic          s_tlast = 1'b0;
  logic          s_tvalid = 1'b0;
  logic          s_tready;
  logic [DW-1:0] m_tdata;
  logic [KW-1:0] m_tkeep;
  logic          m_tlast;
  logic          m_tvalid;
  logic          m_tready = 1'b0;

  int tests = 0;
  int fails = 0;
  int pushed = 0;
  int popped = 0;
  int rdy_mode = 0;   // 0 directed, 1 always ready, 2 random
  bit mon_en = 1'b0;
  logic [EW-1:0] exp_q[$];

  always #10 clk = ~clk;

  axis_loopback_stage #(.DATA_W(DW)) i_axis_loopback_stage (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_axis_tdata  (s_tdata),
    .s_axis_tkeep  (s_tkeep),
    .s_axis_tlast  (s_tlast),
    .s_axis_tvalid (s_tvalid),
    .s_axis_tready (s_tready),
    .m_axis_tdata  (m_tdata),
    .m_axis_tkeep  (m_tkeep),
    .m_axis_tlast  (m_tlast),
    .m_axis_tvalid (m_tvalid),
    .m_axis_tready (m_tready)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: offers one word, records it when the handshake edge passes
  task automatic push_word(input logic [DW-1:0] d, input logic [KW-1:0] k,
                           input logic l, input int gap);
    bit ok;
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = d; s_tkeep = k; s_tlast = l;
    forever begin
      #1 ok = s_tready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    exp_q.push_back({l, k, d});
    pushed++;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      s_tvalid = 1'b0; s_tdata = $urandom; s_tkeep = KW'($urandom); s_tlast = 1'($urandom);
    end
  endtask

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (rdy_mode == 1) m_tready = 1'b1;
    else if (rdy_mode == 2) m_tready = ($urandom % 3) != 0;
    #1;
    if (mon_en && rst_n && m_tvalid && m_tready) begin
      if (exp_q.size() == 0) begin
        check("R5 extra output word", {31'd0, m_tlast, m_tkeep, m_tdata}, 64'hDEAD);
      end else begin
        logic [EW-1:0] e;
        e = exp_q.pop_front();
        popped++;
        check("R8 order/data", 64'(m_tdata), 64'(e[DW-1:0]));
        check("R7 keep", 64'(m_tkeep), 64'(e[DW +: KW]));
        check("R6 last", 64'(m_tlast), 64'(e[EW-1]));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    check("R1 ready in reset", 64'(s_tready), 64'd1);
    check("R1 valid in reset", 64'(m_tvalid), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // Directed: capture, hold under back-pressure, release
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = 32'hA5C3_0F1E; s_tkeep = 4'b0011; s_tlast = 1'b1;
    @(negedge clk);
    s_tdata = 32'h1111_2222; s_tkeep = 4'b1100; s_tlast = 1'b0;
    #2;
    check("R2 valid after accept", 64'(m_tvalid), 64'd1);
    check("R2 data after accept", 64'(m_tdata), 64'hA5C3_0F1E);
    check("R7 keep after accept", 64'(m_tkeep), 64'b0011);
    check("R6 last after accept", 64'(m_tlast), 64'd1);
    check("R3 ready low while sending", 64'(s_tready), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      s_tdata = $urandom; s_tkeep = KW'($urandom); s_tlast = ~s_tlast;
      #2;
      check("R9 input ignored while sending", 64'(m_tdata), 64'hA5C3_0F1E);
      check("R4 keep held", 64'(m_tkeep), 64'b0011);
      check("R4 last held", 64'(m_tlast), 64'd1);
    end
    @(negedge clk);
    s_tvalid = 1'b0; m_tready = 1'b1;
    @(negedge clk);
    m_tready = 1'b0;
    #2;
    check("R5 valid drops after handshake", 64'(m_tvalid), 64'd0);
    check("R5 ready returns", 64'(s_tready), 64'd1);
    m_tready = 1'b1;
    @(negedge clk);
    #2;
    check("R5 no repeat of word", 64'(m_tvalid), 64'd0);
    m_tready = 1'b0;

    // Scoreboard streams
    mon_en = 1'b1;
    rdy_mode = 1;
    for (int i = 0; i < 16; i++)
      push_word($urandom, (i % 4 == 3) ? 4'b0111 : 4'hF, (i % 4 == 3), 0);
    @(negedge clk) s_tvalid = 1'b0;
    rdy_mode = 2;
    for (int i = 0; i < 32; i++)
      push_word($urandom, (i % 5 == 4) ? KW'($urandom | 1) : 4'hF, (i % 5 == 4), $urandom % 3);
    @(negedge clk) s_tvalid = 1'b0;
    repeat (30) @(negedge clk);
    check("R8 all words out once", 64'(popped), 64'(pushed));
    check("R8 queue drained", 64'(exp_q.size()), 64'd0);

    // R1: reset while a word is held
    mon_en = 1'b0;
    rdy_mode = 0;
    m_tready = 1'b0;
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = 32'h0BAD_F00D; s_tkeep = 4'hF; s_tlast = 1'b0;
    @(negedge clk);
    s_tvalid = 1'b0;
    #2 check("R2 held before reset", 64'(m_tvalid), 64'd1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    #2;
    check("R1 valid cleared by reset", 64'(m_tvalid), 64'd0);
    check("R1 ready after reset", 64'(s_tready), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule